// File: doc/BRIEF.md
# Character Cell Raster Address Generator

This block follows the beam of a video raster and reports, for every dot clock, whether the beam is inside the on-screen text area. The text area is a grid of 12 rows by 24 character cells, and each cell is 12 dots wide and 18 scan lines tall at normal size. While the beam is inside the area, the block outputs the text row and column of the cell under the beam, together with the glyph line and the glyph dot inside that cell. A font lookup stage downstream can then fetch the right pixel.

The position of the area is programmable. A 6-bit vertical offset counts scan lines from the field sync. A 6-bit horizontal offset counts dot clocks from the line sync. Four text rows (zero-based rows 0, 1, 8 and 10) each take a 2-bit size code that enlarges every glyph dot and glyph line of that row by two or three. Rows below an enlarged row move down by its extra height. An interlace mode selects how scan lines of the two fields map onto glyph lines.

Top module: `osd_raster_addr`

## Requirements
- R1: While and after reset, `valid_o` is low and the four address outputs are zero until a field sync and a later line sync have started a visible line. `field_o` resets to 0.
- R2: A field sync (`vsync_i` high for one cycle) restarts the vertical count. Scan line n after it (n = 0 for the line begun by the first following `hsync_i`) lies at frame line F = n. F is 2n + `field_o` when interlaced. Position P = F − V, where V is `vstart_i`, or 2·`vstart_i` when interlaced. Text starts at P = 0.
- R3: A line begins in the cycle where `hsync_i` is high, which counts as dot 0. Dot d of the line lies at horizontal position Q = d − 1 − `hstart_i`. Text starts at Q = 0, so with offset 0 the first text dot shows in the cycle right after the line sync.
- R4: With factor k for the current row, Q gives column Q / (12k) in the range 0..23. It gives glyph dot (Q mod 12k) / k in the range 0..11. Q at or beyond 288k is outside the area.
- R5: P walks through the rows in order, 0 to 11. Row r spans 18·k_r scan positions, and the glyph line is (P − start of row r) / k_r, in the range 0..17. P past row 11 is outside the area. Row and glyph line change only when a line begins.
- R6: Size code encoding: 2'b00 and 2'b11 give factor 1, 2'b01 gives factor 2 and 2'b10 gives factor 3. `size_r0_i`, `size_r1_i`, `size_r8_i` and `size_r10_i` apply to zero-based rows 0, 1, 8 and 10. All other rows use factor 1.
- R7: With factor k, each glyph dot lasts k dot clocks and each glyph line lasts k scan positions. The glyph dot advances by at most one per clock within a column.
- R8: On each field sync, `field_o` toggles when `ilace_i` is 1 and clears when `ilace_i` is 0.
- R9: `valid_o` is high only when both P and Q are inside the area. Whenever `valid_o` is low, `row_o`, `col_o`, `grow_o` and `gcol_o` are zero.
- R10: When `vsync_i` and `hsync_i` are high in the same cycle, the field sync wins for the vertical count. That cycle does not count as scan line 0, but the horizontal count still restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_i | input | 1 | One-cycle line start pulse |
| vsync_i | input | 1 | One-cycle field start pulse |
| ilace_i | input | 1 | 1 selects interlaced line counting |
| vstart_i | input | 6 | Vertical offset in scan lines |
| hstart_i | input | 6 | Horizontal offset in dot clocks |
| size_r0_i | input | 2 | Size code for text row 0 |
| size_r1_i | input | 2 | Size code for text row 1 |
| size_r8_i | input | 2 | Size code for text row 8 |
| size_r10_i | input | 2 | Size code for text row 10 |
| valid_o | output | 1 | Beam is inside the text area |
| row_o | output | 4 | Text row 0..11 |
| col_o | output | 5 | Text column 0..23 |
| grow_o | output | 5 | Glyph line 0..17 |
| gcol_o | output | 4 | Glyph dot 0..11 |
| field_o | output | 1 | Current field parity |

## Verification
The bound checker watches, on every clock, the properties that hold cycle by cycle. These are: zero addresses outside the area, the legal ranges of the four address outputs, the row and glyph line holding steady inside a line, the glyph dot stepping by at most one, the column restart when the horizontal offset is zero, and the field parity update at each field sync. The exact positions cannot be checked that way. These include where text begins for a given offset, how the enlarged rows push later rows down, where the area ends at row 11 and column 23, the interlaced frame-line mapping, and what happens when both syncs arrive together. Only the bench's scenarios show these, by comparing every cycle against an arithmetic model.

// File: rtl/osd_raster_pkg.sv
package osd_raster_pkg;

    // default geometry of the text area
    localparam int DEF_ROWS    = 12;
    localparam int DEF_COLS    = 24;
    localparam int DEF_CELL_W  = 12;
    localparam int DEF_CELL_H  = 18;
    localparam int DEF_START_W = 6;

    // rows (zero-based) that own a programmable size code
    localparam int SIZED_ROW_A = 0;
    localparam int SIZED_ROW_B = 1;
    localparam int SIZED_ROW_C = 8;
    localparam int SIZED_ROW_D = 10;

    // number of frame positions stepped per scan line when interlaced
    localparam int IL_STEPS = 2;

    typedef enum logic [1:0] {
        SZ_NORMAL   = 2'b00,
        SZ_DOUBLE   = 2'b01,
        SZ_TRIPLE   = 2'b10,
        SZ_NORMAL_B = 2'b11
    } size_code_e;

    // size code to magnification factor (R6)
    function automatic logic [1:0] size_factor(input logic [1:0] code);
        case (size_code_e'(code))
            SZ_DOUBLE: return 2'd2;
            SZ_TRIPLE: return 2'd3;
            default:   return 2'd1;
        endcase
    endfunction

endpackage

// File: rtl/osd_size_map.sv
module osd_size_map
    import osd_raster_pkg::*;
#(
    parameter int ROWS = DEF_ROWS
) (
    input  logic [1:0]            size_a_i,
    input  logic [1:0]            size_b_i,
    input  logic [1:0]            size_c_i,
    input  logic [1:0]            size_d_i,
    output logic [ROWS-1:0][1:0]  kf_o
);

    // one factor per text row; rows without a code stay at factor 1 (R6)
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        if (r == SIZED_ROW_A) begin : g_a
            assign kf_o[r] = size_factor(size_a_i);
        end else if (r == SIZED_ROW_B) begin : g_b
            assign kf_o[r] = size_factor(size_b_i);
        end else if (r == SIZED_ROW_C) begin : g_c
            assign kf_o[r] = size_factor(size_c_i);
        end else if (r == SIZED_ROW_D) begin : g_d
            assign kf_o[r] = size_factor(size_d_i);
        end else begin : g_n
            assign kf_o[r] = 2'd1;
        end
    end

endmodule

// File: rtl/osd_vwalk.sv
module osd_vwalk
    import osd_raster_pkg::*;
#(
    parameter int ROWS    = DEF_ROWS,
    parameter int CELL_H  = DEF_CELL_H,
    parameter int START_W = DEF_START_W,
    parameter int ROW_W   = $clog2(ROWS + 1),
    parameter int GR_W    = $clog2(CELL_H)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  hsync_i,
    input  logic                  vsync_i,
    input  logic                  ilace_i,
    input  logic [START_W-1:0]    vstart_i,
    input  logic [ROWS-1:0][1:0]  kf_i,
    output logic                  vvalid_o,
    output logic [ROW_W-1:0]      row_o,
    output logic [GR_W-1:0]       grow_o,
    output logic                  field_o
);

    localparam int PRE_W = START_W + 3;
    localparam logic [ROW_W-1:0] ROW_END = ROW_W'(ROWS);
    localparam logic [GR_W-1:0]  GR_LAST = GR_W'(CELL_H - 1);

    typedef struct packed {
        logic              started;
        logic [PRE_W-1:0]  pre;      // negative distance to the first text line
        logic [ROW_W-1:0]  row;
        logic [GR_W-1:0]   gl;
        logic [1:0]        rep;      // repeats of the current glyph line
    } vst_t;

    localparam vst_t V_IDLE = '{started: 1'b1, pre: '0, row: ROW_END, gl: '0, rep: 2'd0};

    // advance by one frame position (R2, R5, R7)
    function automatic vst_t pos_step(input vst_t s);
        vst_t       n;
        logic [1:0] k;
        n = s;
        k = (s.row < ROW_END) ? kf_i[s.row] : 2'd1;
        if (!s.started) begin
            if (&s.pre) begin
                n.started = 1'b1;
                n.row     = '0;
                n.gl      = '0;
                n.rep     = 2'd0;
            end else begin
                n.pre = s.pre + PRE_W'(1);
            end
        end else if (s.row < ROW_END) begin
            if (s.rep == k - 2'd1) begin
                n.rep = 2'd0;
                if (s.gl == GR_LAST) begin
                    n.gl  = '0;
                    n.row = s.row + ROW_W'(1);
                end else begin
                    n.gl = s.gl + GR_W'(1);
                end
            end else begin
                n.rep = s.rep + 2'd1;
            end
        end
        return n;
    endfunction

    vst_t                    st_q;
    vst_t [IL_STEPS:0]       chain;
    logic                    field_q;
    logic                    field_d;
    logic [PRE_W-1:0]        voff;
    logic [PRE_W-1:0]        pre_init;

    // one step per scan line, two when interlaced (each field line covers two frame lines)
    assign chain[0] = st_q;
    for (genvar i = 0; i < IL_STEPS; i++) begin : g_step
        assign chain[i+1] = pos_step(chain[i]);
    end

    assign field_d  = ilace_i & ~field_q;
    assign voff     = ilace_i ? {2'b00, vstart_i, 1'b0} : {3'b000, vstart_i};
    // position held before the first line of the field: parity - offset - step
    assign pre_init = PRE_W'(field_d) - voff - (ilace_i ? PRE_W'(2) : PRE_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= V_IDLE;
            field_q <= 1'b0;
        end else if (vsync_i) begin
            field_q <= field_d;
            st_q    <= '{started: 1'b0, pre: pre_init, row: '0, gl: '0, rep: 2'd0};
        end else if (hsync_i) begin
            st_q <= ilace_i ? chain[IL_STEPS] : chain[1];
        end
    end

    assign vvalid_o = st_q.started && (st_q.row < ROW_END);
    assign row_o    = st_q.row;
    assign grow_o   = st_q.gl;
    assign field_o  = field_q;

endmodule

// File: rtl/osd_hwalk.sv
module osd_hwalk
    import osd_raster_pkg::*;
#(
    parameter int COLS    = DEF_COLS,
    parameter int CELL_W  = DEF_CELL_W,
    parameter int START_W = DEF_START_W,
    parameter int COL_W   = $clog2(COLS + 1),
    parameter int GC_W    = $clog2(CELL_W)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hsync_i,
    input  logic [START_W-1:0]  hstart_i,
    input  logic [1:0]          k_i,
    output logic                hvalid_o,
    output logic [COL_W-1:0]    col_o,
    output logic [GC_W-1:0]     gcol_o
);

    localparam int PRE_W = START_W + 1;
    localparam logic [COL_W-1:0] COL_END = COL_W'(COLS);
    localparam logic [GC_W-1:0]  GC_LAST = GC_W'(CELL_W - 1);

    typedef struct packed {
        logic              started;
        logic [PRE_W-1:0]  pre;
        logic [COL_W-1:0]  col;
        logic [GC_W-1:0]   gc;
        logic [1:0]        rep;
    } hst_t;

    localparam hst_t H_IDLE = '{started: 1'b1, pre: '0, col: COL_END, gc: '0, rep: 2'd0};

    // advance by one dot clock (R3, R4, R7)
    function automatic hst_t dot_step(input hst_t s);
        hst_t n;
        n = s;
        if (!s.started) begin
            if (&s.pre) begin
                n.started = 1'b1;
                n.col     = '0;
                n.gc      = '0;
                n.rep     = 2'd0;
            end else begin
                n.pre = s.pre + PRE_W'(1);
            end
        end else if (s.col < COL_END) begin
            if (s.rep == k_i - 2'd1) begin
                n.rep = 2'd0;
                if (s.gc == GC_LAST) begin
                    n.gc  = '0;
                    n.col = s.col + COL_W'(1);
                end else begin
                    n.gc = s.gc + GC_W'(1);
                end
            end else begin
                n.rep = s.rep + 2'd1;
            end
        end
        return n;
    endfunction

    hst_t st_q;
    hst_t load_raw;
    hst_t load_val;

    // the sync cycle is dot 0; position before it is -(offset + 1)
    assign load_raw = '{started: 1'b0, pre: ~{1'b0, hstart_i}, col: '0, gc: '0, rep: 2'd0};
    assign load_val = dot_step(load_raw);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= H_IDLE;
        end else if (hsync_i) begin
            st_q <= load_val;
        end else begin
            st_q <= dot_step(st_q);
        end
    end

    assign hvalid_o = st_q.started && (st_q.col < COL_END);
    assign col_o    = st_q.col;
    assign gcol_o   = st_q.gc;

endmodule

// File: rtl/osd_raster_addr.sv
module osd_raster_addr
    import osd_raster_pkg::*;
#(
    parameter int ROWS    = DEF_ROWS,
    parameter int COLS    = DEF_COLS,
    parameter int CELL_W  = DEF_CELL_W,
    parameter int CELL_H  = DEF_CELL_H,
    parameter int START_W = DEF_START_W,
    localparam int ROW_W  = $clog2(ROWS + 1),
    localparam int COL_W  = $clog2(COLS + 1),
    localparam int GR_W   = $clog2(CELL_H),
    localparam int GC_W   = $clog2(CELL_W)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hsync_i,
    input  logic                vsync_i,
    input  logic                ilace_i,
    input  logic [START_W-1:0]  vstart_i,
    input  logic [START_W-1:0]  hstart_i,
    input  logic [1:0]          size_r0_i,
    input  logic [1:0]          size_r1_i,
    input  logic [1:0]          size_r8_i,
    input  logic [1:0]          size_r10_i,
    output logic                valid_o,
    output logic [ROW_W-1:0]    row_o,
    output logic [COL_W-1:0]    col_o,
    output logic [GR_W-1:0]     grow_o,
    output logic [GC_W-1:0]     gcol_o,
    output logic                field_o
);

    logic [ROWS-1:0][1:0] kf;
    logic                 vvalid;
    logic [ROW_W-1:0]     vrow;
    logic [GR_W-1:0]      vgrow;
    logic                 hvalid;
    logic [COL_W-1:0]     hcol;
    logic [GC_W-1:0]      hgcol;
    logic [1:0]           cur_k;

    osd_size_map #(.ROWS(ROWS)) u_size (
        .size_a_i (size_r0_i),
        .size_b_i (size_r1_i),
        .size_c_i (size_r8_i),
        .size_d_i (size_r10_i),
        .kf_o     (kf)
    );

    osd_vwalk #(
        .ROWS(ROWS), .CELL_H(CELL_H), .START_W(START_W), .ROW_W(ROW_W), .GR_W(GR_W)
    ) u_vwalk (
        .clk      (clk),
        .rst      (rst),
        .hsync_i  (hsync_i),
        .vsync_i  (vsync_i),
        .ilace_i  (ilace_i),
        .vstart_i (vstart_i),
        .kf_i     (kf),
        .vvalid_o (vvalid),
        .row_o    (vrow),
        .grow_o   (vgrow),
        .field_o  (field_o)
    );

    // the row under the beam sets the horizontal magnification
    assign cur_k = vvalid ? kf[vrow] : 2'd1;

    osd_hwalk #(
        .COLS(COLS), .CELL_W(CELL_W), .START_W(START_W), .COL_W(COL_W), .GC_W(GC_W)
    ) u_hwalk (
        .clk      (clk),
        .rst      (rst),
        .hsync_i  (hsync_i),
        .hstart_i (hstart_i),
        .k_i      (cur_k),
        .hvalid_o (hvalid),
        .col_o    (hcol),
        .gcol_o   (hgcol)
    );

    // R9: addresses forced to zero outside the text area
    assign valid_o = vvalid & hvalid;
    assign row_o   = valid_o ? vrow  : '0;
    assign grow_o  = valid_o ? vgrow : '0;
    assign col_o   = valid_o ? hcol  : '0;
    assign gcol_o  = valid_o ? hgcol : '0;

endmodule

// File: rtl/osd_raster_addr_chk.sv
module osd_raster_addr_chk #(
    parameter int ROWS    = 12,
    parameter int COLS    = 24,
    parameter int CELL_W  = 12,
    parameter int CELL_H  = 18,
    parameter int START_W = 6,
    localparam int ROW_W  = $clog2(ROWS + 1),
    localparam int COL_W  = $clog2(COLS + 1),
    localparam int GR_W   = $clog2(CELL_H),
    localparam int GC_W   = $clog2(CELL_W)
) (
    input logic                clk,
    input logic                rst,
    input logic                hsync_i,
    input logic                vsync_i,
    input logic                ilace_i,
    input logic [START_W-1:0]  hstart_i,
    input logic                valid_o,
    input logic [ROW_W-1:0]    row_o,
    input logic [COL_W-1:0]    col_o,
    input logic [GR_W-1:0]     grow_o,
    input logic [GC_W-1:0]     gcol_o,
    input logic                field_o
);

    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    p_zero_outside_r9: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> (row_o == '0 && col_o == '0 && grow_o == '0 && gcol_o == '0));

    p_col_range_r4: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (gcol_o < GC_W'(CELL_W) && col_o < COL_W'(COLS)));

    p_row_range_r5: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (grow_o < GR_W'(CELL_H) && row_o < ROW_W'(ROWS)));

    p_row_hold_r5: assert property (@(posedge clk) disable iff (rst)
        past_ok && valid_o && $past(valid_o) && !$past(hsync_i) && !$past(vsync_i)
        |-> (row_o == $past(row_o) && grow_o == $past(grow_o)));

    p_gcol_step_r7: assert property (@(posedge clk) disable iff (rst)
        past_ok && valid_o && $past(valid_o) && !$past(hsync_i) && col_o == $past(col_o)
        |-> (gcol_o == $past(gcol_o) || gcol_o == $past(gcol_o) + GC_W'(1)));

    p_hstart_zero_r3: assert property (@(posedge clk) disable iff (rst)
        hsync_i && hstart_i == '0 |=> (!valid_o || (col_o == '0 && gcol_o == '0)));

    p_field_clear_r8: assert property (@(posedge clk) disable iff (rst)
        vsync_i && !ilace_i |=> !field_o);

    p_field_toggle_r8: assert property (@(posedge clk) disable iff (rst)
        vsync_i && ilace_i |=> field_o != $past(field_o));

endmodule

bind osd_raster_addr osd_raster_addr_chk #(
    .ROWS(ROWS), .COLS(COLS), .CELL_W(CELL_W), .CELL_H(CELL_H), .START_W(START_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .hsync_i  (hsync_i),
    .vsync_i  (vsync_i),
    .ilace_i  (ilace_i),
    .hstart_i (hstart_i),
    .valid_o  (valid_o),
    .row_o    (row_o),
    .col_o    (col_o),
    .grow_o   (grow_o),
    .gcol_o   (gcol_o),
    .field_o  (field_o)
);

// File: tb/osd_raster_addr_bench.sv
module osd_raster_addr_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hsync = 1'b0;
    logic       vsync = 1'b0;
    logic       ilace = 1'b0;
    logic [5:0] vstart = 6'd0;
    logic [5:0] hstart = 6'd0;
    logic [1:0] sz0 = 2'd0;
    logic [1:0] sz1 = 2'd0;
    logic [1:0] sz8 = 2'd0;
    logic [1:0] sz10 = 2'd0;

    logic       valid_o;
    logic [3:0] row_o;
    logic [4:0] col_o;
    logic [4:0] grow_o;
    logic [3:0] gcol_o;
    logic       field_o;

    osd_raster_addr u_osd_raster_addr (
        .clk        (clk),
        .rst        (rst),
        .hsync_i    (hsync),
        .vsync_i    (vsync),
        .ilace_i    (ilace),
        .vstart_i   (vstart),
        .hstart_i   (hstart),
        .size_r0_i  (sz0),
        .size_r1_i  (sz1),
        .size_r8_i  (sz8),
        .size_r10_i (sz10),
        .valid_o    (valid_o),
        .row_o      (row_o),
        .col_o      (col_o),
        .grow_o     (grow_o),
        .gcol_o     (gcol_o),
        .field_o    (field_o)
    );

    always #5 clk = ~clk;

    typedef struct packed {
        logic       valid;
        logic [3:0] row;
        logic [4:0] col;
        logic [4:0] grow;
        logic [3:0] gcol;
        logic       field;
    } exp_t;

    exp_t  q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    int    field_m = 0;
    int    nline = -2;   // -2: no field sync yet, -1: field sync seen, no line yet
    int    dcnt = 0;     // 0: no line sync yet
    string scen = "R1";

    // R6 factor model
    function automatic int kfac(input int r);
        int c;
        c = (r == 0) ? int'(sz0) : (r == 1) ? int'(sz1) : (r == 8) ? int'(sz8) :
            (r == 10) ? int'(sz10) : 0;
        return (c == 1) ? 2 : (c == 2) ? 3 : 1;
    endfunction

    // arithmetic model of R2..R5, R7..R9
    function automatic exp_t model();
        exp_t e;
        int   f, p, k, qd, vr, vg;
        bit   vok;
        e = '0;
        e.field = field_m[0];
        vok = 0; vr = 0; vg = 0;
        if (nline >= 0) begin
            f = ilace ? 2 * nline + field_m : nline;
            p = f - (ilace ? 2 * int'(vstart) : int'(vstart));
            if (p >= 0) begin
                for (int r = 0; r < 12; r++) begin
                    if (!vok) begin
                        k = kfac(r);
                        if (p < 18 * k) begin
                            vok = 1; vr = r; vg = p / k;
                        end else begin
                            p = p - 18 * k;
                        end
                    end
                end
            end
        end
        if (vok && dcnt >= 1) begin
            k  = kfac(vr);
            qd = dcnt - 1 - int'(hstart);
            if (qd >= 0 && qd < 24 * 12 * k) begin
                e.valid = 1'b1;
                e.row   = 4'(vr);
                e.grow  = 5'(vg);
                e.col   = 5'(qd / (12 * k));
                e.gcol  = 4'((qd % (12 * k)) / k);
            end
        end
        return e;
    endfunction

    // driver: one clock of stimulus, expected result queued
    task automatic cyc(input logic hs, input logic vs);
        @(negedge clk);
        hsync = hs;
        vsync = vs;
        if (vs) begin
            field_m = ilace ? 1 - field_m : 0;
            nline   = -1;
        end else if (hs && nline >= -1) begin
            nline++;
        end
        if (hs) dcnt = 1;
        else if (dcnt >= 1) dcnt++;
        q.push_back(model());
    endtask

    task automatic run_lines(input int n, input int len);
        for (int i = 0; i < n; i++) begin
            cyc(1'b1, 1'b0);
            for (int j = 1; j < len; j++) cyc(1'b0, 1'b0);
        end
    endtask

    task automatic run_field(input int n, input int len);
        cyc(1'b0, 1'b1);
        run_lines(n, len);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // monitor: compares away from the clock edge
    always @(posedge clk) begin
        exp_t  e;
        string tag;
        #2;
        if (!done && q.size() > 0) begin
            e = q.pop_front();
            checks++;
            tag = "";
            if (valid_o !== e.valid) tag = "R9";
            else if (field_o !== e.field) tag = "R8";
            else if (row_o !== e.row || grow_o !== e.grow) tag = "R5";
            else if (col_o !== e.col || gcol_o !== e.gcol) tag = "R4";
            if (tag != "") begin
                errors++;
                $display("FAIL %s [%s] got v=%0b row=%0d col=%0d grow=%0d gcol=%0d fld=%0b exp v=%0b row=%0d col=%0d grow=%0d gcol=%0d fld=%0b",
                         tag, scen, valid_o, row_o, col_o, grow_o, gcol_o, field_o,
                         e.valid, e.row, e.col, e.grow, e.gcol, e.field);
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired exp finish got hang");
            finish_up();
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if (valid_o !== 1'b0 || row_o !== 4'd0 || col_o !== 5'd0 || grow_o !== 5'd0 ||
            gcol_o !== 4'd0 || field_o !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset got v=%0b row=%0d col=%0d grow=%0d gcol=%0d fld=%0b exp all zero",
                     valid_o, row_o, col_o, grow_o, gcol_o, field_o);
        end
        @(negedge clk);
        rst = 1'b0;
        // R1: line syncs before any field sync stay outside the area
        scen = "R1";
        repeat (4) cyc(1'b0, 1'b0);
        run_lines(2, 20);

        // R2 R3 R4 R5: normal size, offsets 3 lines / 5 dots, through the last row
        scen = "R2 R3 R4 R5";
        vstart = 6'd3; hstart = 6'd5;
        run_field(230, 40);

        // R6 R7: mixed size codes, code 11 on row 8 acts as normal
        scen = "R6 R7";
        sz0 = 2'b01; sz1 = 2'b10; sz8 = 2'b11; sz10 = 2'b01;
        vstart = 6'd0; hstart = 6'd0;
        run_field(300, 60);

        // R3 R7 R4: largest horizontal offset, triple row 0, full width to column 23
        scen = "R3 R4 R7";
        sz0 = 2'b10; sz1 = 2'b00; sz8 = 2'b00; sz10 = 2'b00;
        hstart = 6'd63;
        run_field(4, 940);

        // R8: interlaced, two fields with opposite parity
        scen = "R8";
        sz0 = 2'b00;
        ilace = 1'b1; vstart = 6'd2; hstart = 6'd1;
        run_field(115, 30);
        run_field(115, 30);
        // R8: leaving interlace clears the parity
        ilace = 1'b0;
        run_field(5, 30);

        // R10: both syncs in one cycle
        scen = "R10";
        vstart = 6'd0; hstart = 6'd0;
        cyc(1'b1, 1'b1);
        for (int j = 1; j < 30; j++) cyc(1'b0, 1'b0);
        run_lines(20, 30);

        repeat (4) cyc(1'b0, 1'b0);
        while (q.size() > 0) @(posedge clk);
        @(negedge clk);
        finish_up();
    end

endmodule